// File: doc/BRIEF.md
# 8-bit ALU with status flags

The block is an 8-bit arithmetic and logic unit with a registered status byte beside it. Two operands and an opcode produce a result on the same cycle, combinationally. The carry that feeds the carry-using operations comes from the stored status byte. When the execute strobe is high, each operation writes only the flags it defines into the status byte at the next clock edge. Every other status bit keeps its value.

The status byte holds, from bit 7 down: interrupt enable (7), bit-transfer flag (6), half carry H (5), sign S (4), overflow V (3), negative N (2), zero Z (1) and carry C (0). Bits 7 and 6 are only stored. They change through the direct load port and through reset, never through an operation. The surrounding datapath uses the direct load port to restore or preset the whole byte.

Top module: `alu8_flags`

## Requirements
- R1: While rst_ni is low the status byte sreg_o is 0x00, asynchronously.
- R2: Opcode 0 (add) gives A+B and opcode 1 (add with carry) gives A+B+C. C is the carry out of bit 7, H is the carry out of bit 3, and V flags two's-complement overflow. All six arithmetic flags (H,S,V,N,Z,C) update.
- R3: Opcode 2 (subtract) gives A−B and opcode 3 (subtract with carry) gives A−B−C. C is set on a borrow out of bit 7, H on a borrow out of bit 3, and V on signed overflow. All six arithmetic flags update.
- R4: Opcode 4 (increment) and opcode 5 (decrement) update S, V, N and Z only. V is set when increment turns 0x7F into 0x80 or decrement turns 0x80 into 0x7F. C and H are kept.
- R5: Opcode 6 (negate) gives 0x00−A. It updates all six arithmetic flags. C is set unless A is 0x00, and V is set exactly when A is 0x80.
- R6: Opcodes 7, 8 and 9 (AND, OR, XOR of A and B) update S, N and Z and clear V, keeping C and H. Opcode 10 (complement) gives 0xFF−A, sets C, clears V, updates S, N and Z, and keeps H.
- R7: Opcode 11 (shift left) fills bit 0 with 0. Opcode 12 (logical shift right) fills bit 7 with 0. Opcode 15 (arithmetic shift right) keeps bit 7. C takes the bit shifted out, V = N XOR C, S, N and Z update, and H is kept.
- R8: Opcode 13 (rotate left) moves old C into bit 0 and bit 7 into C. Opcode 14 (rotate right) moves old C into bit 7 and bit 0 into C. Flags update as for the shifts in R7.
- R9: Opcode 16 (swap) exchanges the two nibbles of A and changes no status bit.
- R10: For every operation that writes them, N is result bit 7, Z is set when the result is 0x00, and S equals N XOR V.
- R11: With load_i high the status byte takes load_data_i at the next edge, and it wins over exec_i in the same cycle. With neither strobe the byte holds. An operation never changes bits 7 and 6.
- R12: Opcodes 17 to 31 are reserved: res_o equals A and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Commit the flags of the current operation at the next edge |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (the only operand for unary operations) |
| b_i | input | 8 | Second operand |
| load_i | input | 1 | Load the whole status byte |
| load_data_i | input | 8 | Value for the status byte load |
| res_o | output | 8 | Combinational result |
| sreg_o | output | 8 | Registered status byte |

## Verification
The direct load and an executed operation can fall in the same cycle. The bench raises load_i and exec_i together with an operation that would set several flags, then checks that the byte equals the loaded value and shows none of the operation's flags. A second overlap is a carry-using operation in the cycle right after a load. Every table and model vector presets C through the load port and then runs the operation on the following cycle, so the result shows whether the freshly loaded carry was used.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OPW = 5;

  localparam int unsigned FB_C = 0;
  localparam int unsigned FB_Z = 1;
  localparam int unsigned FB_N = 2;
  localparam int unsigned FB_V = 3;
  localparam int unsigned FB_S = 4;
  localparam int unsigned FB_H = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_INC  = 5'd4,  OP_DEC  = 5'd5,  OP_NEG  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_COM  = 5'd10, OP_LSL  = 5'd11,
    OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // bits each operation is allowed to write in the status byte
  function automatic logic [7:0] flag_mask(input logic [OPW-1:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:  flag_mask = 8'h3F;
      OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR:   flag_mask = 8'h1E;
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR:                                  flag_mask = 8'h1F;
      default:                                 flag_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic           c_o,
  output logic           h_o,
  output logic           v_o
);
  localparam int unsigned HB = W / 2;

  logic [W-1:0]  x, y;
  logic          ci, sub;
  logic [W:0]    sum;
  logic [HB:0]   nib;

  // every arithmetic op maps onto x + y + ci; subtraction inverts y and the carries
  always_comb begin
    x   = a_i;
    y   = b_i;
    ci  = 1'b0;
    sub = 1'b0;
    case (op_i)
      OP_ADC: ci = cin_i;
      OP_SUB: begin y = ~b_i; ci = 1'b1;   sub = 1'b1; end
      OP_SBC: begin y = ~b_i; ci = ~cin_i; sub = 1'b1; end
      OP_INC: begin y = '0;   ci = 1'b1; end
      OP_DEC: begin y = '1;   ci = 1'b0; end
      OP_NEG: begin x = '0;   y = ~a_i; ci = 1'b1; sub = 1'b1; end
      default: ;
    endcase
  end

  assign sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign nib   = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, ci};
  assign res_o = sum[W-1:0];
  assign c_o   = sum[W] ^ sub;
  assign h_o   = nib[HB] ^ sub;
  assign v_o   = (x[W-1] ~^ y[W-1]) & (x[W-1] ^ sum[W-1]);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           cin_i,
  output logic [W-1:0]   res_o,
  output logic           c_o,
  output logic           v_o
);
  localparam int unsigned HB = W / 2;

  logic is_shift;

  always_comb begin
    res_o    = a_i;
    c_o      = cin_i;
    is_shift = 1'b1;
    case (op_i)
      OP_AND:  begin res_o = a_i & b_i; is_shift = 1'b0; end
      OP_OR:   begin res_o = a_i | b_i; is_shift = 1'b0; end
      OP_XOR:  begin res_o = a_i ^ b_i; is_shift = 1'b0; end
      OP_COM:  begin res_o = ~a_i; c_o = 1'b1; is_shift = 1'b0; end
      OP_LSL:  begin res_o = {a_i[W-2:0], 1'b0};     c_o = a_i[W-1]; end
      OP_LSR:  begin res_o = {1'b0, a_i[W-1:1]};     c_o = a_i[0];   end
      OP_ROL:  begin res_o = {a_i[W-2:0], cin_i};    c_o = a_i[W-1]; end
      OP_ROR:  begin res_o = {cin_i, a_i[W-1:1]};    c_o = a_i[0];   end
      OP_ASR:  begin res_o = {a_i[W-1], a_i[W-1:1]}; c_o = a_i[0];   end
      OP_SWAP: begin res_o = {a_i[HB-1:0], a_i[W-1:HB]}; is_shift = 1'b0; end
      default: is_shift = 1'b0;
    endcase
  end

  assign v_o = is_shift & (res_o[W-1] ^ c_o);
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           load_i,
  input  logic [7:0]     load_data_i,
  output logic [DW-1:0]  res_o,
  output logic [7:0]     sreg_o
);
  logic [DW-1:0] ar_res, bo_res;
  logic          ar_c, ar_h, ar_v, bo_c, bo_v;
  logic          arith_sel, rsvd_sel;
  logic [7:0]    flg, mask, sreg_q;

  alu8_arith #(.W(DW)) u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_i(sreg_q[FB_C]),
    .res_o(ar_res), .c_o(ar_c), .h_o(ar_h), .v_o(ar_v)
  );

  alu8_bitops #(.W(DW)) u_bitops (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .cin_i(sreg_q[FB_C]),
    .res_o(bo_res), .c_o(bo_c), .v_o(bo_v)
  );

  assign arith_sel = (op_i <= OP_NEG);
  assign rsvd_sel  = (op_i > OP_SWAP);
  assign mask      = flag_mask(op_i);

  always_comb begin
    if (rsvd_sel)       res_o = a_i;
    else if (arith_sel) res_o = ar_res;
    else                res_o = bo_res;
    flg       = '0;
    flg[FB_C] = arith_sel ? ar_c : bo_c;
    flg[FB_H] = ar_h;
    flg[FB_V] = arith_sel ? ar_v : bo_v;
    flg[FB_N] = res_o[DW-1];
    flg[FB_Z] = (res_o == '0);
    flg[FB_S] = flg[FB_N] ^ flg[FB_V];
  end

  // whole-byte load wins over an executed operation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= load_data_i;
    else if (exec_i)  sreg_q <= (sreg_q & ~mask) | (flg & mask);
  end

  assign sreg_o = sreg_q;

  p_load_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sreg_o == $past(load_data_i));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !exec_i) |=> $stable(sreg_o));
  p_upper_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !load_i) |=> sreg_o[7:6] == $past(sreg_o[7:6]));
  p_sign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !load_i && mask[FB_S]) |=> sreg_o[FB_S] == (sreg_o[FB_N] ^ sreg_o[FB_V]));
  p_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !load_i && mask[FB_Z]) |=> sreg_o[FB_Z] == ($past(res_o) == '0));
  p_swap_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !load_i && op_i == OP_SWAP) |=> $stable(sreg_o));
  p_incdec_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !load_i && (op_i == OP_INC || op_i == OP_DEC))
      |=> (sreg_o[FB_C] == $past(sreg_o[FB_C])) && (sreg_o[FB_H] == $past(sreg_o[FB_H])));
  p_rsvd_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_SWAP) |-> res_o == a_i);
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  import alu8_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       load = 1'b0;
  logic [7:0] load_data = '0;
  logic [7:0] res, sreg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op), .a_i(a), .b_i(b),
    .load_i(load), .load_data_i(load_data), .res_o(res), .sreg_o(sreg)
  );

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a, b, init, res, sreg;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{5'd0,  8'h7F, 8'h01, 8'h00, 8'h80, 8'h2C},  // R2 add overflow
    '{5'd1,  8'hFF, 8'h00, 8'h01, 8'h00, 8'h23},  // R2 adc wrap
    '{5'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'h35},  // R3 borrow
    '{5'd3,  8'h80, 8'h00, 8'h01, 8'h7F, 8'h38},  // R3 sbc overflow
    '{5'd4,  8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D},  // R4 inc keeps C,H
    '{5'd5,  8'h01, 8'h00, 8'h00, 8'h00, 8'h02},  // R4 dec to zero
    '{5'd6,  8'h80, 8'h00, 8'h00, 8'h80, 8'h0D},  // R5 neg 0x80
    '{5'd7,  8'hF0, 8'h0F, 8'h29, 8'h00, 8'h23},  // R6 and clears V
    '{5'd10, 8'h55, 8'h00, 8'h00, 8'hAA, 8'h15},  // R6 com sets C
    '{5'd11, 8'h81, 8'h00, 8'h00, 8'h02, 8'h19},  // R7 lsl
    '{5'd12, 8'h01, 8'h00, 8'h20, 8'h00, 8'h3B},  // R7 lsr keeps H
    '{5'd15, 8'h81, 8'h00, 8'h00, 8'hC0, 8'h15},  // R7 asr
    '{5'd14, 8'h01, 8'h00, 8'h01, 8'h80, 8'h15},  // R8 ror carry in
    '{5'd13, 8'h80, 8'h00, 8'h00, 8'h00, 8'h1B},  // R8 rol carry out
    '{5'd16, 8'h3C, 8'h00, 8'hC5, 8'hC3, 8'hC5}   // R9 swap
  };

  function automatic string req_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd1:                 return "R2";
      5'd2, 5'd3:                 return "R3";
      5'd4, 5'd5:                 return "R4";
      5'd6:                       return "R5";
      5'd7, 5'd8, 5'd9, 5'd10:    return "R6";
      5'd11, 5'd12, 5'd15:        return "R7";
      5'd13, 5'd14:               return "R8";
      5'd16:                      return "R9";
      default:                    return "R12";
    endcase
  endfunction

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // behavioural model: {result, next status byte}
  function automatic logic [15:0] ref_model(input logic [4:0] o, input logic [7:0] ia,
                                            input logic [7:0] ib, input logic [7:0] s);
    int ua, ub, ci, t, st;
    logic [7:0] r, m, f;
    logic fc, fh, fv;
    ua = int'(ia); ub = int'(ib); ci = int'(s[0]);
    fc = s[0]; fh = s[5]; fv = 1'b0; r = ia; m = 8'h00;
    case (o)
      5'd0, 5'd1: begin
        if (o == 5'd0) ci = 0;
        t = ua + ub + ci; r = t[7:0]; fc = t > 255;
        fh = ((ua % 16) + (ub % 16) + ci) > 15;
        st = sgn(ua) + sgn(ub) + ci; fv = (st > 127) || (st < -128); m = 8'h3F;
      end
      5'd2, 5'd3, 5'd6: begin
        if (o == 5'd2) ci = 0;
        if (o == 5'd6) begin ub = ua; ua = 0; ci = 0; end
        t = ua - ub - ci; r = t[7:0]; fc = t < 0;
        fh = ((ua % 16) - (ub % 16) - ci) < 0;
        st = sgn(ua) - sgn(ub) - ci; fv = (st > 127) || (st < -128); m = 8'h3F;
      end
      5'd4: begin t = ua + 1; r = t[7:0]; fv = (ua == 127); m = 8'h1E; end
      5'd5: begin t = ua - 1; r = t[7:0]; fv = (ua == 128); m = 8'h1E; end
      5'd7:  begin r = ia & ib; m = 8'h1E; end
      5'd8:  begin r = ia | ib; m = 8'h1E; end
      5'd9:  begin r = ia ^ ib; m = 8'h1E; end
      5'd10: begin t = 255 - ua; r = t[7:0]; fc = 1'b1; m = 8'h1F; end
      5'd11: begin t = (ua * 2) % 256; r = t[7:0]; fc = ia[7]; m = 8'h1F; end
      5'd12: begin t = ua / 2; r = t[7:0]; fc = ia[0]; m = 8'h1F; end
      5'd13: begin t = (ua * 2) % 256 + ci; r = t[7:0]; fc = ia[7]; m = 8'h1F; end
      5'd14: begin t = ua / 2 + ci * 128; r = t[7:0]; fc = ia[0]; m = 8'h1F; end
      5'd15: begin t = ua / 2 + (ua >= 128 ? 128 : 0); r = t[7:0]; fc = ia[0]; m = 8'h1F; end
      5'd16: begin t = (ua % 16) * 16 + ua / 16; r = t[7:0]; end
      default: ;
    endcase
    if (o >= 5'd11 && o <= 5'd15) fv = r[7] ^ fc;
    f = {2'b00, fh, r[7] ^ fv, fv, r[7], r == 8'h00, fc};
    return {r, (s & ~m) | (f & m)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] o, input logic [7:0] ia, input logic [7:0] ib,
                        input logic [7:0] init, input logic [7:0] er, input logic [7:0] es);
    @(negedge clk);
    load = 1'b1; load_data = init; exec = 1'b0;
    @(negedge clk);
    load = 1'b0; exec = 1'b1; op = o; a = ia; b = ib;
    #1 chk({req_of(o), " result"}, int'(res), int'(er));
    @(negedge clk);
    exec = 1'b0;
    chk({req_of(o), " flags R10"}, int'(sreg), int'(es));
  endtask

  task automatic run_model(input logic [4:0] o, input logic [7:0] ia, input logic [7:0] ib,
                           input logic [7:0] init);
    logic [15:0] e;
    e = ref_model(o, ia, ib, init);
    run_op(o, ia, ib, init, e[15:8], e[7:0]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] corners [4];
    logic [15:0] e;
    corners = '{8'h00, 8'h7F, 8'h80, 8'hFF};

    // R1: reset state
    #(CLK_PERIOD * 2);
    chk("R1 reset", int'(sreg), 0);
    @(negedge clk); rst_n = 1'b1;

    foreach (VECS[i])
      run_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].init, VECS[i].res, VECS[i].sreg);

    for (int o = 0; o < 17; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            run_model(5'(o), corners[i], corners[j], {2'b10, 5'b00000, 1'(c)});

    for (int k = 0; k < 1500; k++)
      run_model(5'($urandom_range(0, 16)), 8'($urandom), 8'($urandom), 8'($urandom));

    // R12: reserved opcodes pass A and leave flags alone
    for (int o = 17; o < 32; o += 5)
      run_op(5'(o), 8'h96, 8'h33, 8'h5A, 8'h96, 8'h5A);

    // R11: load and exec together, load wins
    @(negedge clk);
    load = 1'b1; load_data = 8'h00;
    @(negedge clk);
    load = 1'b1; load_data = 8'hC0; exec = 1'b1; op = 5'd2; a = 8'h00; b = 8'h01;
    @(negedge clk);
    load = 1'b0; exec = 1'b0;
    chk("R11 load priority", int'(sreg), 8'hC0);

    // R11: idle cycles hold the byte while operands move
    a = 8'h00; b = 8'hFF; op = 5'd3;
    @(negedge clk); a = 8'h80; op = 5'd6;
    @(negedge clk);
    chk("R11 idle hold", int'(sreg), 8'hC0);

    // R11: an operation keeps bits 7 and 6
    e = ref_model(5'd0, 8'hFF, 8'h01, 8'hC0);
    run_op(5'd0, 8'hFF, 8'h01, 8'hC0, e[15:8], e[7:0]);
    chk("R11 upper bits", int'(sreg[7:6]), 3);

    // R1: asynchronous reset mid-run
    @(negedge clk); load = 1'b1; load_data = 8'hFF;
    @(negedge clk); load = 1'b0;
    #2 rst_n = 1'b0;
    #1 chk("R1 async reset", int'(sreg), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule